// File: doc/BRIEF.md
# Paged GPIO Controller with Edge Interrupts

This block provides 48 general-purpose lines, organised as six 8-bit ports, behind a small 8-bit register bus. Each port has a single data register. A 1 written to a bit makes the block actively drive that line (open-drain style). A 0 releases the line so that it can serve as an input. Reading a data register returns the synchronized level of its lines, not the stored value.

Ports 0 to 2 can also raise edge-triggered interrupts. Each of these 24 lines has three bits: one for edge polarity, one for enable and one for pending status. The polarity, enable and status banks do not have their own addresses. They appear one at a time in a shared three-byte window, and the page field of a control byte picks which bank the window shows. Software selects a page and then reads or writes the bank for ports 0 to 2.

A single interrupt request output is raised while any pending bit is set. The register bus is a plain synchronous write strobe with a combinational read, with no handshake. Every access completes in one cycle, so back-pressure never occurs.

Top module: `pgpio_top`

## Requirements
- R1: After a synchronous reset: every data register, the page field and every polarity, enable and status bit is 0. pin_drive is all zeros and irq is low.
- R2: A write to offset p (0 to 5) loads reg_wdata into data register p on that clock edge. pin_drive bit p*8+n equals bit n of that register, and pin_drive changes only on such writes.
- R3: A read of offset p (0 to 5) returns pin_in bits p*8+7..p*8 as they were sampled two clock edges earlier (two-flop synchronizer).
- R4: Offset 7 is the page control byte. A write stores reg_wdata[7:6] as the page field. A read returns the page in bits 7:6 and zeros in bits 5:0. The page changes only on a write to offset 7.
- R5: Offsets 8, 9 and 10 address ports 0, 1 and 2 of the bank selected by the page: 1 = polarity, 2 = enable, 3 = status. Polarity and enable take the written byte. With page 0 the window reads zero and ignores writes.
- R6: An enabled interrupt line sets its status bit on a rising synchronized edge when its polarity bit is 1, and on a falling edge when it is 0. The bit becomes visible three clock edges after pin_in changes, and it stays set until cleared.
- R7: A line whose enable bit is 0 never sets its status bit. Lines of ports 3 to 5 have no status and never affect irq.
- R8: Writing the status page clears each bit written as 1 and leaves bits written as 0 unchanged. An edge detected in the same cycle as the clear leaves the bit set.
- R9: irq is high exactly when at least one status bit is set.
- R10: Offset 6 and offsets 11 to 15 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pin_in | input | 48 | Sampled line levels |
| pin_drive | output | 48 | 1 = line actively driven, 0 = released |
| irq | output | 1 | Interrupt request, high while any status bit is set |

## Verification
Assertions check several invariants on every cycle:
- the two-cycle synchronizer delay;
- no status bit rises unless the line was enabled;
- no status bit falls without a clear write;
- a cleared bit with no coincident edge is zero;
- the page field, the enable bank and pin_drive hold their values between writes.

Some behaviour shows only in the bench's scenarios, which it compares against a behavioural model on every clock:
- the polarity-dependent choice of edge;
- the exact three-edge latency;
- the edge that coincides with a clear;
- page 0 and the reserved offsets ignoring writes;
- the readback format of each page.

// File: rtl/pgpio_pkg.sv
package pgpio_pkg;
  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_STAT = 2'd3
  } page_t;

  localparam int PORT_W_DEF    = 8;
  localparam int PORTS_DEF     = 6;
  localparam int IRQ_PORTS_DEF = 3;
  localparam int ADDR_W_DEF    = 4;
endpackage

// File: rtl/pgpio_sync.sv
module pgpio_sync #(
  parameter int N  = 48,
  parameter int NI = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  cur,
  output logic [NI-1:0] prev
);
  logic [N-1:0]  s1_q, s2_q;
  logic [NI-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= s2_q[NI-1:0];
    end
  end

  assign cur  = s2_q;
  assign prev = prev_q;

  // R3
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (cur == $past(pin_in, 2)));
endmodule

// File: rtl/pgpio_irq_port.sv
module pgpio_irq_port #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] cur,
  input  logic [PW-1:0] prev,
  input  logic          wr_pol,
  input  logic          wr_en,
  input  logic          wr_stat,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] pol_q,
  output logic [PW-1:0] en_q,
  output logic [PW-1:0] stat_q
);
  logic [PW-1:0] rise, fall, hit, clr;

  assign rise = cur & ~prev;
  assign fall = ~cur & prev;
  assign hit  = en_q & ((pol_q & rise) | (~pol_q & fall));
  assign clr  = wr_stat ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= '0;
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (wr_pol) pol_q <= wdata;
      if (wr_en)  en_q  <= wdata;
      stat_q <= (stat_q & ~clr) | hit;
    end
  end

  // R7
  stat_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~$past(stat_q) & ~$past(en_q)) == '0);
  // R6
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (~stat_q & $past(stat_q) & ~$past(clr)) == '0);
  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q & $past(clr & ~hit)) == '0);
  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(en_q));
endmodule

// File: rtl/pgpio_top.sv
module pgpio_top
  import pgpio_pkg::*;
#(
  parameter int PORTS     = PORTS_DEF,
  parameter int IRQ_PORTS = IRQ_PORTS_DEF,
  parameter int PW        = PORT_W_DEF,
  parameter int AW        = ADDR_W_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [AW-1:0]       reg_addr,
  input  logic [PW-1:0]       reg_wdata,
  output logic [PW-1:0]       reg_rdata,
  input  logic [PORTS*PW-1:0] pin_in,
  output logic [PORTS*PW-1:0] pin_drive,
  output logic                irq
);
  localparam int NL = PORTS * PW;
  localparam int NI = IRQ_PORTS * PW;
  localparam logic [AW-1:0] PAGE_A = AW'(PORTS + 1);
  localparam int BANK_BASE = PORTS + 2;

  logic [1:0]                      page_q;
  logic [PORTS-1:0][PW-1:0]        data_q;
  logic [NL-1:0]                   sync_cur;
  logic [NI-1:0]                   sync_prev;
  logic [IRQ_PORTS-1:0][PW-1:0]    pol_q, en_q, st_q;

  pgpio_sync #(.N(NL), .NI(NI)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .cur(sync_cur), .prev(sync_prev)
  );

  always_ff @(posedge clk) begin
    if (rst) page_q <= 2'd0;
    else if (reg_we && reg_addr == PAGE_A) page_q <= reg_wdata[PW-1 -: 2];
  end

  genvar gp;
  generate
    for (gp = 0; gp < PORTS; gp++) begin : g_data
      always_ff @(posedge clk) begin
        if (rst) data_q[gp] <= '0;
        else if (reg_we && reg_addr == AW'(gp)) data_q[gp] <= reg_wdata;
      end
    end

    for (gp = 0; gp < IRQ_PORTS; gp++) begin : g_irq
      logic sel;
      assign sel = reg_we && (reg_addr == AW'(BANK_BASE + gp));
      pgpio_irq_port #(.PW(PW)) u_port (
        .clk(clk), .rst(rst),
        .cur(sync_cur[gp*PW +: PW]),
        .prev(sync_prev[gp*PW +: PW]),
        .wr_pol(sel && page_t'(page_q) == PG_POL),
        .wr_en(sel && page_t'(page_q) == PG_EN),
        .wr_stat(sel && page_t'(page_q) == PG_STAT),
        .wdata(reg_wdata),
        .pol_q(pol_q[gp]), .en_q(en_q[gp]), .stat_q(st_q[gp])
      );
    end
  endgenerate

  assign pin_drive = data_q;
  assign irq       = |st_q;

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < PORTS; p++)
      if (reg_addr == AW'(p)) reg_rdata = sync_cur[p*PW +: PW];
    if (reg_addr == PAGE_A) reg_rdata = {page_q, {(PW-2){1'b0}}};
    for (int k = 0; k < IRQ_PORTS; k++) begin
      if (reg_addr == AW'(BANK_BASE + k)) begin
        unique case (page_t'(page_q))
          PG_POL:  reg_rdata = pol_q[k];
          PG_EN:   reg_rdata = en_q[k];
          PG_STAT: reg_rdata = st_q[k];
          default: reg_rdata = '0;
        endcase
      end
    end
  end

  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_we && reg_addr == PAGE_A) |-> $stable(page_q));
  // R2
  drive_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_we && reg_addr < AW'(PORTS)) |-> $stable(pin_drive));
endmodule

// File: tb/pgpio_top_tb.sv
module pgpio_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] pin = '0;
  logic [47:0] drive;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit run_cmp = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pgpio_top dut_i (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .pin_in(pin), .pin_drive(drive), .irq(irq)
  );

  // Behavioural reference model
  logic [7:0]  m_data [6];
  logic [7:0]  m_pol [3];
  logic [7:0]  m_en [3];
  logic [7:0]  m_st [3];
  logic [1:0]  m_page;
  logic [47:0] hist [$];

  task automatic model_step();
    logic [7:0] hits [3];
    logic [47:0] lvl, old;
    if (rst) begin
      for (int i = 0; i < 6; i++) m_data[i] = 8'h00;
      for (int i = 0; i < 3; i++) begin m_pol[i] = 0; m_en[i] = 0; m_st[i] = 0; end
      m_page = 2'd0;
      hist = '{48'h0, 48'h0, 48'h0};
    end else begin
      lvl = hist[1];
      old = hist[2];
      for (int k = 0; k < 3; k++)
        for (int b = 0; b < 8; b++) begin
          int i = k * 8 + b;
          bit up = lvl[i] && !old[i];
          bit dn = !lvl[i] && old[i];
          hits[k][b] = m_en[k][b] && (m_pol[k][b] ? up : dn);
        end
      if (we) begin
        if (addr < 6) m_data[addr] = wdata;
        else if (addr == 7) m_page = wdata[7:6];
        else if (addr >= 8 && addr <= 10) begin
          case (m_page)
            2'd1: m_pol[addr-8] = wdata;
            2'd2: m_en[addr-8] = wdata;
            2'd3: m_st[addr-8] = m_st[addr-8] & ~wdata;
            default: ;
          endcase
        end
      end
      for (int k = 0; k < 3; k++) m_st[k] = m_st[k] | hits[k];
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    logic [47:0] lv;
    lv = hist[1];
    if (a < 6) return lv[a*8 +: 8];
    if (a == 7) return {m_page, 6'b0};
    if (a >= 8 && a <= 10) begin
      case (m_page)
        2'd1: return m_pol[a-8];
        2'd2: return m_en[a-8];
        2'd3: return m_st[a-8];
        default: return 8'h00;
      endcase
    end
    return 8'h00;
  endfunction

  function automatic string read_tag(input logic [3:0] a);
    if (a < 6) return "R3";
    if (a == 7) return "R4";
    if (a >= 8 && a <= 10) return "R5";
    return "R10";
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [47:0] edrv;
    logic        eirq;
    model_step();
    #3;
    if (run_cmp && !rst && !done) begin
      for (int p = 0; p < 6; p++) edrv[p*8 +: 8] = m_data[p];
      eirq = (m_st[0] | m_st[1] | m_st[2]) != 0;
      chk("R2 drive", {16'h0, drive}, {16'h0, edrv});
      chk("R9 irq", {63'h0, irq}, {63'h0, eirq});
      chk(read_tag(addr), {56'h0, rdata}, {56'h0, exp_read(addr)});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1 v = rdata;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    waitn(4);
    rst = 1'b0;
    run_cmp = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 drive", {16'h0, drive}, 64'h0);
    chk("R1 irq", {63'h0, irq}, 64'h0);
    rd(4'd7, v); chk("R1 page", {56'h0, v}, 64'h0);
    wr(4'd7, 8'hC0);
    rd(4'd8, v); chk("R1 status", {56'h0, v}, 64'h0);
    // R2 drive mapping
    wr(4'd0, 8'hA5);
    wr(4'd5, 8'h3C);
    @(negedge clk); #1;
    chk("R2 map", {16'h0, drive}, 64'h3C00_0000_00A5);
    // R3 synchronized readback
    pin = 48'h0000_0000_5A00;
    waitn(3);
    rd(4'd1, v); chk("R3 level", {56'h0, v}, 64'h5A);
    // R4 page field
    wr(4'd7, 8'hFF);
    rd(4'd7, v); chk("R4 readback", {56'h0, v}, 64'hC0);
    // R5 banks
    wr(4'd7, 8'h40); wr(4'd8, 8'hFF);
    wr(4'd7, 8'h80); wr(4'd8, 8'h0F);
    wr(4'd7, 8'h00); wr(4'd9, 8'hFF);
    rd(4'd9, v); chk("R5 page0 read", {56'h0, v}, 64'h0);
    wr(4'd7, 8'h40);
    rd(4'd9, v); chk("R5 page0 write ignored", {56'h0, v}, 64'h0);
    rd(4'd8, v); chk("R5 polarity", {56'h0, v}, 64'hFF);
    wr(4'd7, 8'h80);
    rd(4'd8, v); chk("R5 enable", {56'h0, v}, 64'h0F);
    wr(4'd7, 8'hC0);
    // R6 rising edges, R7 unenabled and port 3
    pin = 48'h0000_FF00_5AFF;
    waitn(4);
    rd(4'd8, v); chk("R6 R7 rising", {56'h0, v}, 64'h0F);
    rd(4'd9, v); chk("R7 port1 no enable", {56'h0, v}, 64'h0);
    chk("R9 irq high", {63'h0, irq}, 64'h1);
    // R8 clear semantics
    wr(4'd8, 8'h01);
    rd(4'd8, v); chk("R8 clear one", {56'h0, v}, 64'h0E);
    wr(4'd8, 8'h00);
    rd(4'd8, v); chk("R8 zero keeps", {56'h0, v}, 64'h0E);
    wr(4'd8, 8'h0E);
    rd(4'd8, v); chk("R8 clear rest", {56'h0, v}, 64'h0);
    #1 chk("R9 irq low", {63'h0, irq}, 64'h0);
    // R7 port 3 toggling leaves irq low
    pin = 48'h0000_0000_5A00;
    waitn(4);
    chk("R7 port3 ignored", {63'h0, irq}, 64'h0);
    // R8 edge coincident with clear
    @(negedge clk); pin[0] = 1'b1;
    @(negedge clk);
    wr(4'd8, 8'h01);
    rd(4'd8, v); chk("R8 edge wins", {56'h0, v}, 64'h01);
    wr(4'd8, 8'hFF);
    // R6 falling polarity
    wr(4'd7, 8'h40); wr(4'd8, 8'h00); wr(4'd7, 8'hC0);
    pin[0] = 1'b0;
    waitn(4);
    rd(4'd8, v); chk("R6 falling", {56'h0, v}, 64'h01);
    // R10 reserved offsets
    wr(4'd6, 8'hFF);
    rd(4'd6, v); chk("R10 offset6", {56'h0, v}, 64'h0);
    wr(4'd15, 8'hFF);
    rd(4'd15, v); chk("R10 offset15", {56'h0, v}, 64'h0);
    @(negedge clk); #1;
    chk("R10 drive unchanged", {16'h0, drive}, 64'h3C00_0000_00A5);
    // randomized phase, compared against the model every clock
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      we = ($urandom % 3) == 0;
      addr = 4'($urandom % 16);
      wdata = 8'($urandom);
      if (($urandom % 4) == 0) pin = {16'($urandom), 32'($urandom)};
    end
    @(negedge clk); we = 1'b0;
    waitn(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule